// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned W-bit integer by another and returns a W-bit quotient and a W-bit remainder, one trial bit per clock. A pulse on `start` while the block is idle captures both operands. The divisor is placed in the upper half of a double-width shift register, and the dividend goes into the lower half of a double-width partial-remainder register. On every working cycle the divisor register is subtracted from the partial remainder. A borrow means the old value is kept, which acts as an implicit restore, and a 0 is shifted into the quotient. No borrow means the difference replaces the partial remainder and a 1 is shifted in. The divisor register then moves one place to the right.

The block makes W+1 trials, so `busy` stays high for W+1 cycles. One cycle of `done` follows, and the results on `quotient` and `remainder` then stay put until the next accepted start. A zero divisor is not special-cased: every trial succeeds, which leaves an all-ones quotient and the untouched dividend as the remainder. A flag marks that case together with `done`.

Top module: `rdiv_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: A start seen while idle makes `busy` high from the next cycle on, for exactly W+1 consecutive cycles.
- R3: `done` is high for exactly one cycle, which is the first cycle after `busy` falls.
- R4: For a nonzero divisor, in the `done` cycle `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, so that dividend = quotient × divisor + remainder.
- R5: For a nonzero divisor the reported remainder is strictly less than the divisor.
- R6: For a zero divisor, `div_zero` is high in the `done` cycle, `quotient` is all ones and `remainder` equals the dividend.
- R7: `div_zero` is high only in a `done` cycle, and only when the captured divisor was zero.
- R8: A start seen while `busy` is high is ignored. The running operation finishes with its originally captured operands and the same cycle count.
- R9: While idle after an operation, `quotient` and `remainder` keep their values until the next accepted start.
- R10: With W = 4, dividend 4'b0111 and divisor 4'b0010 give quotient 4'b0011 and remainder 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a division; accepted only while idle |
| dividend | input | W | Unsigned dividend, captured on an accepted start |
| divisor | input | W | Unsigned divisor, captured on an accepted start |
| busy | output | 1 | High while trial subtractions are in progress |
| done | output | 1 | One-cycle pulse marking valid results |
| quotient | output | W | Quotient of the last completed division |
| remainder | output | W | Remainder of the last completed division |
| div_zero | output | 1 | High with `done` when the divisor was zero |

## Verification
The bench builds the divider with W = 4. At that width all 256 dividend/divisor pairs can be run, so every borrow pattern across the five trials is exercised. This also covers the zero divisor against every dividend and the all-ones extremes, and the worked 7 / 2 case falls out of the same sweep. Starts raised in the middle of an operation, with different operands, show that the small width leaves no room for a stray capture to go unnoticed.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rdiv_state_e;

    typedef struct packed {
        logic load;   // capture operands this edge
        logic step;   // perform one trial this edge
        logic last;   // this trial is the final one
    } rdiv_ctl_t;

    // counter must reach W (the index of the final trial)
    function automatic int rdiv_cnt_bits(input int w);
        return $clog2(w + 2);
    endfunction

endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output rdiv_ctl_t ctl,
    output logic      busy,
    output logic      done
);
    localparam int            CW   = rdiv_cnt_bits(W);
    localparam logic [CW-1:0] LAST = CW'(W);

    rdiv_state_e   state;
    logic [CW-1:0] cnt;

    always_comb begin
        ctl.load = (state == ST_IDLE) && start;
        ctl.step = (state == ST_RUN);
        ctl.last = (state == ST_RUN) && (cnt == LAST);
    end

    assign busy = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= ctl.last;
            if (ctl.load) begin
                state <= ST_RUN;
                cnt   <= '0;
            end else if (ctl.last) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else if (ctl.step) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rdiv_trial.sv
module rdiv_trial #(
    parameter int W2 = 16
) (
    input  logic [W2-1:0] part_rem,
    input  logic [W2-1:0] shifted_den,
    output logic [W2-1:0] diff,
    output logic          fits
);
    logic [W2:0] wide;

    assign wide = {1'b0, part_rem} - {1'b0, shifted_den};
    assign fits = ~wide[W2];
    assign diff = wide[W2-1:0];
endmodule

// File: rtl/rdiv_dpath.sv
module rdiv_dpath
    import rdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  rdiv_ctl_t    ctl,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         zero_seen
);
    localparam int W2 = 2 * W;

    logic [W2-1:0] rem_q;
    logic [W2-1:0] den_q;
    logic [W-1:0]  quo_q;
    logic [W2-1:0] diff;
    logic          fits;

    rdiv_trial #(.W2(W2)) u_trial (
        .part_rem    (rem_q),
        .shifted_den (den_q),
        .diff        (diff),
        .fits        (fits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q     <= '0;
            den_q     <= '0;
            quo_q     <= '0;
            zero_seen <= 1'b0;
        end else if (ctl.load) begin
            rem_q     <= {{W{1'b0}}, dividend};
            den_q     <= {divisor, {W{1'b0}}};
            quo_q     <= '0;
            zero_seen <= (divisor == '0);
        end else if (ctl.step) begin
            if (fits) begin
                rem_q <= diff;
            end
            quo_q <= {quo_q[W-2:0], fits};
            den_q <= den_q >> 1;
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q[W-1:0];
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top
    import rdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_zero
);
    rdiv_ctl_t ctl;
    logic      zero_seen;

    rdiv_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    rdiv_dpath #(.W(W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder),
        .zero_seen (zero_seen)
    );

    assign div_zero = done & zero_seen;
endmodule

// File: rtl/rdiv_check.sv
module rdiv_check #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_zero
);
    localparam int RW = $clog2(W + 3);

    logic [RW-1:0] run_len;
    logic [W-1:0]  cap_dd;
    logic [W-1:0]  cap_ds;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            cap_dd  <= '0;
            cap_ds  <= '0;
        end else begin
            run_len <= busy ? run_len + 1'b1 : '0;
            if (start && !busy) begin
                cap_dd <= dividend;
                cap_ds <= divisor;
            end
        end
    end

    // R2 / R8: every operation occupies exactly W+1 busy cycles
    assert_busy_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == RW'(W + 1)));

    assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4 / R8: result matches the operands captured at the accepted start
    assert_identity_R4: assert property (@(posedge clk) disable iff (rst)
        (done && cap_ds != '0) |->
            ({{W{1'b0}}, cap_dd} == {{W{1'b0}}, quotient} * {{W{1'b0}}, cap_ds}
                                    + {{W{1'b0}}, remainder}));

    assert_rem_below_div_R5: assert property (@(posedge clk) disable iff (rst)
        (done && cap_ds != '0) |-> (remainder < cap_ds));

    assert_zero_result_R6: assert property (@(posedge clk) disable iff (rst)
        (done && cap_ds == '0) |-> (div_zero && quotient == '1 && remainder == cap_dd));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> (done && cap_ds == '0));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> ($stable(quotient) && $stable(remainder)));
endmodule

bind rdiv_top rdiv_check #(.W(W)) u_rdiv_check (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_zero  (div_zero)
);

// File: tb/rdiv_top_bench.sv
module rdiv_top_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rdiv_top #(.W(W)) u_rdiv_top (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder),
        .div_zero  (div_zero)
    );

    // behavioural reference
    bit m_busy = 0, m_done = 0, m_have = 0, exp_z = 0;
    int m_cnt = 0;
    int exp_q = 0, exp_r = 0, cap_b = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_have = 0; m_cnt = 0;
            exp_q = 0; exp_r = 0; exp_z = 0; cap_b = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == W + 1) begin
                    m_busy = 0; m_done = 1; m_have = 1;
                end
            end else if (start) begin
                m_busy = 1; m_cnt = 0;
                cap_b = int'(divisor);
                if (divisor == 0) begin
                    exp_q = (1 << W) - 1; exp_r = int'(dividend); exp_z = 1;
                end else begin
                    exp_q = int'(dividend) / int'(divisor);
                    exp_r = int'(dividend) % int'(divisor);
                    exp_z = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    // compare on every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(busy == m_busy, "R2 busy", int'(busy), int'(m_busy));
            check(done == m_done, "R3 done", int'(done), int'(m_done));
            check(div_zero == (m_done && exp_z), "R7 div_zero", int'(div_zero), int'(m_done && exp_z));
            if (m_have && !m_busy) begin
                check(quotient == W'(exp_q), exp_z ? "R6 quotient" : "R4 quotient",
                      int'(quotient), exp_q);
                check(remainder == W'(exp_r), exp_z ? "R6 remainder" : "R9 remainder",
                      int'(remainder), exp_r);
            end
            if (m_done && !exp_z)
                check(int'(remainder) < cap_b, "R5 remainder below divisor", int'(remainder), cap_b);
        end
    end

    task automatic run_op(input int a, input int b, input bit poke);
        @(negedge clk);
        dividend = W'(a); divisor = W'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dividend = ~dividend; divisor = ~divisor;
        if (poke) begin
            // R8: a second start with other operands mid-operation
            @(negedge clk);
            dividend = W'(a + 5); divisor = W'(b + 3); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!m_done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(!busy && !done && !div_zero, "R1 flags in reset", int'({busy, done, div_zero}), 0);
        check(quotient == '0 && remainder == '0, "R1 results in reset",
              int'({quotient, remainder}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && quotient == '0 && remainder == '0, "R1 after reset",
              int'({busy, quotient, remainder}), 0);

        // R10: worked example 7 / 2
        run_op(7, 2, 0);
        check(quotient == 4'b0011, "R10 quotient", int'(quotient), 3);
        check(remainder == 4'b0001, "R10 remainder", int'(remainder), 1);

        // R9: results stay while idle
        repeat (5) @(negedge clk);
        check(quotient == 4'b0011 && remainder == 4'b0001, "R9 hold",
              int'({quotient, remainder}), 8'h31);

        // R6: zero divisor
        run_op(11, 0, 0);
        check(quotient == 4'b1111 && remainder == 4'd11, "R6 zero divisor",
              int'({quotient, remainder}), 8'hFB);

        // R8: starts during busy are ignored
        run_op(13, 4, 1);
        check(quotient == 4'd3 && remainder == 4'd1, "R8 ignored start",
              int'({quotient, remainder}), 8'h31);
        run_op(15, 0, 1);

        // R4 / R5 / R6: exhaustive sweep
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_op(a, b, ((a + b) % 7) == 0);

        // back-to-back: start in the done cycle
        @(negedge clk);
        dividend = 4'd9; divisor = 4'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        dividend = 4'd14; divisor = 4'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        @(negedge clk);
        check(quotient == 4'd4 && remainder == 4'd2, "R4 back-to-back",
              int'({quotient, remainder}), 8'h42);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule